// File: doc/BRIEF.md
# Iterative Multiply and Divide Unit

This block is a multi-cycle arithmetic unit for a short execute-stage pipeline. It computes a product by adding the multiplicand into an accumulator once per clock. It computes an unsigned quotient and remainder by subtracting the divisor once per clock. Results land in two result registers, Lo and Hi, which move-from instructions elsewhere in the pipeline read directly.

The execute stage raises `start_i` while a multiply or divide sits in it. The unit latches both operands and the operation in that same cycle. It also drives `stall_o` high at once, so the pipeline holds still. The stall stays high while the unit iterates. The unit writes the final values at the edge that ends the last stalled cycle. The following cycle, with stall low, is a completion cycle: the results are already visible there, and a request still present on `start_i` is not taken. The pipeline therefore advances exactly once past the instruction, and the instruction after it reads the fresh Lo and Hi. The run time depends on the data: a multiply takes the multiplier plus one cycle, and a divide takes the quotient plus one cycle.

Top module: `itermd_unit`

## Requirements
- R1: After reset, `lo_o` and `hi_o` are zero and `stall_o` is low.
- R2: With the unit idle, `start_i` high takes a request. `op_i` = 0 selects multiply and `op_i` = 1 selects divide. `a_i`, `b_i` and `op_i` are captured at the end of that cycle, and later changes to them do not affect the result.
- R3: A multiply writes the low WIDTH bits of `a_i` times `b_i` to Lo and leaves Hi unchanged.
- R4: A multiply with `b_i` > 0 keeps `stall_o` high for exactly `b_i` + 1 cycles, starting with the request cycle. With `b_i` = 0 it stalls for one cycle and writes Lo = 0.
- R5: A divide with `b_i` > 0 writes the unsigned quotient floor(`a_i`/`b_i`) to Lo and the remainder to Hi (for example, 7 divided by 3 gives Lo = 2 and Hi = 1).
- R6: A divide with `b_i` > 0 keeps `stall_o` high for exactly floor(`a_i`/`b_i`) + 1 cycles, so a dividend smaller than the divisor stalls for one cycle.
- R7: A divide with `b_i` = 0 stalls for one cycle. It writes Lo = all ones and Hi = `a_i`.
- R8: `stall_o` falls in the cycle right after the final write, and the new Lo and Hi are visible in that cycle. A `start_i` still high in that cycle is ignored: stall stays low and the results stay unchanged.
- R9: Lo and Hi change only at a clock edge that ends a cycle in which `stall_o` was high.
- R10: `stall_o` rises only in a cycle in which `start_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request for an operation, held by the pipeline while the instruction is in execute |
| op_i | input | 1 | Operation select: 0 multiply, 1 divide |
| a_i | input | WIDTH | Multiplicand or dividend |
| b_i | input | WIDTH | Multiplier or divisor |
| stall_o | output | 1 | Pipeline freeze while an operation is in progress |
| lo_o | output | WIDTH | Lo result register (product or quotient) |
| hi_o | output | WIDTH | Hi result register (remainder) |

## Verification
Two events can fall in the same cycle: the completion of an operation, and a request that the pipeline is still holding on `start_i`. Every directed scenario keeps `start_i` high through the completion cycle, and also scrambles the operands and the operation there. If the unit took that request, the stall would rise again and the result registers would be overwritten. The bench therefore checks the exact stall length, the results in the completion cycle, and the results one cycle later. The zero-divisor, zero-multiplier and small-dividend cases make capture and completion coincide at a single edge.

// File: rtl/itermd_pkg.sv
package itermd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctl_state_e;

    localparam logic OP_MUL = 1'b0;
    localparam logic OP_DIV = 1'b1;

    typedef struct packed {
        ctl_state_e st;
    } ctl_regs_t;

endpackage

// File: rtl/itermd_ctrl.sv
module itermd_ctrl
    import itermd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic fin_i,
    output logic cap_o,
    output logic run_o,
    output logic stall_o
);

    ctl_regs_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        cap_o = 1'b0;
        run_o = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    cap_o  = 1'b1;
                    r_d.st = fin_i ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                run_o = 1'b1;
                if (fin_i) r_d.st = ST_DONE;
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
        stall_o = cap_o | run_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.st <= ST_IDLE;
        else        r_q    <= r_d;
    end

endmodule

// File: rtl/itermd_dpath.sv
module itermd_dpath
    import itermd_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic             run_i,
    input  logic             op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             fin_o,
    output logic             op_div_o,
    output logic [WIDTH-1:0] lo_o,
    output logic [WIDTH-1:0] hi_o
);

    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ZERO = '0;

    typedef struct packed {
        logic             div;
        logic [WIDTH-1:0] opd;
        logic [WIDTH-1:0] acc;
        logic [WIDTH-1:0] cnt;
        logic [WIDTH-1:0] lo;
        logic [WIDTH-1:0] hi;
    } dp_regs_t;

    dp_regs_t r_d, r_q;
    logic [WIDTH-1:0] sum_w, diff_w, cnt_up_w;

    always_comb begin
        sum_w    = r_q.acc + r_q.opd;
        diff_w   = r_q.acc - r_q.opd;
        cnt_up_w = r_q.cnt + ONE;
        r_d      = r_q;
        fin_o    = 1'b0;
        if (cap_i) begin
            r_d.div = op_i;
            if (op_i == OP_MUL) begin
                r_d.opd = a_i;
                r_d.acc = ZERO;
                r_d.cnt = b_i;
                if (b_i == ZERO) begin
                    fin_o    = 1'b1;
                    r_d.lo   = ZERO;
                end
            end else begin
                r_d.opd = b_i;
                r_d.acc = a_i;
                r_d.cnt = ZERO;
                if (b_i == ZERO) begin
                    fin_o  = 1'b1;
                    r_d.lo = '1;
                    r_d.hi = a_i;
                end else if (a_i < b_i) begin
                    fin_o  = 1'b1;
                    r_d.lo = ZERO;
                    r_d.hi = a_i;
                end
            end
        end else if (run_i) begin
            if (r_q.div == OP_MUL) begin
                r_d.acc = sum_w;
                r_d.cnt = r_q.cnt - ONE;
                if (r_q.cnt == ONE) begin
                    fin_o  = 1'b1;
                    r_d.lo = sum_w;
                end
            end else begin
                r_d.acc = diff_w;
                r_d.cnt = cnt_up_w;
                if (diff_w < r_q.opd) begin
                    fin_o  = 1'b1;
                    r_d.lo = cnt_up_w;
                    r_d.hi = diff_w;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign op_div_o = r_q.div;
    assign lo_o     = r_q.lo;
    assign hi_o     = r_q.hi;

endmodule

// File: rtl/itermd_unit.sv
module itermd_unit
    import itermd_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             stall_o,
    output logic [WIDTH-1:0] lo_o,
    output logic [WIDTH-1:0] hi_o
);

    logic cap_w, run_w, fin_w, op_div_w;

    itermd_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .fin_i   (fin_w),
        .cap_o   (cap_w),
        .run_o   (run_w),
        .stall_o (stall_o)
    );

    itermd_dpath #(.WIDTH(WIDTH)) u_dpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap_w),
        .run_i    (run_w),
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .fin_o    (fin_w),
        .op_div_o (op_div_w),
        .lo_o     (lo_o),
        .hi_o     (hi_o)
    );

endmodule

// File: rtl/itermd_chk.sv
module itermd_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             stall_o,
    input logic [WIDTH-1:0] lo_o,
    input logic [WIDTH-1:0] hi_o,
    input logic             cap_w,
    input logic             run_w,
    input logic             fin_w,
    input logic             op_div_w
);

    AST_RISE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> start_i); // R10

    AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stall_o) |-> ($stable(lo_o) && $stable(hi_o))); // R9

    AST_FALL_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall_o) |-> $past(fin_w)); // R8

    AST_MUL_RUN_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && !op_div_w) |=> $stable(hi_o)); // R3

    AST_MUL_CAP_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_w && !op_i) |=> $stable(hi_o)); // R3

    AST_MUL_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_w && !op_i && b_i == '0) |=> (lo_o == '0 && !stall_o)); // R4

    AST_DIV_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_w && op_i && b_i == '0) |=> (lo_o == '1 && hi_o == $past(a_i))); // R7

endmodule

bind itermd_unit itermd_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .stall_o  (stall_o),
    .lo_o     (lo_o),
    .hi_o     (hi_o),
    .cap_w    (cap_w),
    .run_w    (run_w),
    .fin_w    (fin_w),
    .op_div_w (op_div_w)
);

// File: tb/sim_itermd_unit.sv
module sim_itermd_unit;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int WATCHDOG   = 100000;
    localparam int CYC_LIMIT  = 5000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         op_i = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         stall_o;
    logic [W-1:0] lo_o, hi_o;

    int checks = 0;
    int errors = 0;
    int ticks  = 0;
    logic [W-1:0] model_hi = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    itermd_unit #(.WIDTH(W)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .op_i    (op_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .stall_o (stall_o),
        .lo_o    (lo_o),
        .hi_o    (hi_o)
    );

    always @(posedge clk) begin
        ticks <= ticks + 1;
        if (ticks > WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired act=%0d exp<=%0d", ticks, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // One scenario: request held through completion, operands scrambled after capture.
    task automatic run_op(input logic op, input logic [W-1:0] a, input logic [W-1:0] b,
                          input string rq_res, input string rq_cyc);
        logic [W-1:0] exp_lo, exp_hi;
        int exp_cyc;
        int cyc;
        if (op == 1'b0) begin
            exp_lo  = a * b;
            exp_hi  = model_hi;
            exp_cyc = (b == '0) ? 1 : int'(b) + 1;
        end else if (b == '0) begin
            exp_lo  = '1;
            exp_hi  = a;
            exp_cyc = 1;
        end else begin
            exp_lo  = a / b;
            exp_hi  = a % b;
            exp_cyc = int'(a / b) + 1;
        end
        @(negedge clk);
        start_i = 1'b1;
        op_i    = op;
        a_i     = a;
        b_i     = b;
        #1;
        cyc = 0;
        while (stall_o && cyc < CYC_LIMIT) begin
            cyc = cyc + 1;
            @(negedge clk);
            op_i = ~op;
            a_i  = a ^ 32'h5A5A_0F0F;
            b_i  = b + 32'd3;
            #1;
        end
        // completion cycle: start still high, stall must be low
        chk(cyc == exp_cyc, rq_cyc, "stall length", W'(cyc), W'(exp_cyc));
        chk(lo_o == exp_lo, rq_res, "lo (R2 capture)", lo_o, exp_lo);
        chk(hi_o == exp_hi, rq_res, "hi", hi_o, exp_hi);
        @(negedge clk);
        start_i = 1'b0;
        #1;
        chk(!stall_o, "R8", "stall after completion", W'(stall_o), '0);
        chk(lo_o == exp_lo && hi_o == exp_hi, "R8", "lo kept after ignored start",
            lo_o, exp_lo);
        model_hi = exp_hi;
    endtask

    initial begin
        #(CLK_PERIOD * 3);
        #1;
        chk(lo_o == '0, "R1", "reset lo", lo_o, '0);
        chk(hi_o == '0, "R1", "reset hi", hi_o, '0);
        chk(!stall_o, "R1", "reset stall", W'(stall_o), '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!stall_o && lo_o == '0, "R1", "idle after reset", lo_o, '0);

        // divide first so Hi is nonzero before multiplies (R3 hi keep)
        run_op(1'b1, 32'd7,   32'd3,  "R5", "R6");
        run_op(1'b0, 32'd3,   32'd4,  "R3", "R4");
        run_op(1'b0, 32'd9,   32'd0,  "R3", "R4");
        run_op(1'b0, 32'd0,   32'd5,  "R3", "R4");
        run_op(1'b0, 32'hFFFF_FFFF, 32'd7, "R3", "R4");
        run_op(1'b0, 32'h1234_5678, 32'd1, "R3", "R4");
        run_op(1'b1, 32'd2,   32'd5,  "R5", "R6");
        run_op(1'b1, 32'd12,  32'd4,  "R5", "R6");
        run_op(1'b1, 32'd0,   32'd3,  "R5", "R6");
        run_op(1'b1, 32'd100, 32'd1,  "R5", "R6");
        run_op(1'b1, 32'hDEAD_BEEF, 32'd0, "R7", "R7");
        run_op(1'b0, 32'd6,   32'd2,  "R3", "R4");
        run_op(1'b1, 32'hFFFF_FFF0, 32'h4000_0000, "R5", "R6");

        // R9 / R10: idle inputs toggling without start do nothing
        @(negedge clk);
        op_i = 1'b1;
        a_i  = 32'd50;
        b_i  = 32'd0;
        @(negedge clk);
        #1;
        chk(!stall_o, "R10", "no stall without start", W'(stall_o), '0);
        chk(hi_o == model_hi, "R9", "hi held while idle", hi_o, model_hi);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule